// File: doc/BRIEF.md
# Serial ADC Readout Shift Engine

This block is the device-side digital front end of a 16-clock serial conversion-and-readout port for a 12-bit converter. The chip-select and serial-clock pins arrive asynchronously. A fast system clock samples both through two-flop synchronizers and finds their edges by comparing successive synchronized samples. The conversion result is presented on a parallel input. It is captured when chip-select falls, which also places the sampler in hold and starts a frame.

A frame has sixteen bit positions: four zeros, then the 12 result bits, most significant first. The first zero is driven as soon as the chip-select falling edge is seen, before any serial clock. Each later serial-clock falling edge moves the line to the next position. The sampler returns to track on the 14th falling edge, and the output goes back to high impedance on the 16th, where a one-cycle done pulse is raised. If chip-select rises before the 16th falling edge, the frame is dropped at once. A host reads the line on serial-clock falling edges, or on rising edges after it has taken the first zero.

Top module: `adc_rd_top`

## Requirements
- R1: During and right after reset, sdata_oe_o, hold_o, done_o and sdata_o are all 0.
- R2: Three system clocks after a chip-select falling edge reaches cs_ni, sdata_oe_o and hold_o are 1 and sdata_o shows the first frame bit, which is 0.
- R3: After the k-th serial-clock falling edge of a frame (k from 1 to 15), sdata_o shows frame bit k. Bits 0 to 3 are 0, and bit 4+j is result bit DATA_W-1-j (most significant bit first).
- R4: hold_o stays 1 through the 13th serial-clock falling edge of a frame and goes to 0 on the 14th.
- R5: On the 16th serial-clock falling edge, sdata_oe_o goes to 0 and done_o is 1 for exactly one system clock. No other event raises done_o.
- R6: A chip-select rise before the 16th falling edge clears sdata_oe_o and hold_o, and done_o is not raised.
- R7: Serial-clock edges seen while chip-select is high are ignored. The output stays in high impedance, and the next frame still starts from bit 0.
- R8: The result word is captured at the chip-select falling edge. Later changes on result_i do not alter the bits being shifted out.
- R9: Serial-clock falling edges after the 16th, with chip-select still low, leave sdata_oe_o at 0 and do not raise done_o.
- R10: Whenever sdata_oe_o is 0, sdata_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than the serial clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip-select, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous |
| result_i | input | DATA_W | Conversion result, captured at the chip-select fall |
| sdata_o | output | 1 | Serial data bit |
| sdata_oe_o | output | 1 | Output enable for the data pad; 0 means high impedance |
| hold_o | output | 1 | 1 while the sampler is in hold |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
A wrong bit count in the frame counter shows up on the data line within one serial clock. The line shows a zero where a result bit was expected, or the reverse, and the track and high-impedance transitions move to the wrong falling edge. A missed abort leaves the output enable high after chip-select rises, which is visible three system clocks later. The bench sweeps result patterns and abort positions at every bit so that each of these faults reaches the ports.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int unsigned LEAD_ZEROS = 4;
  localparam int unsigned SYNC_DEPTH = 2;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;
endpackage

// File: rtl/adc_rd_sync.sv
module adc_rd_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o,
  output logic [WIDTH-1:0] prev_o
);
  logic [STAGES-1:0][WIDTH-1:0] stg_q;
  logic [WIDTH-1:0]             prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < int'(STAGES); s++) stg_q[s] <= RST_VAL;
      prev_q <= RST_VAL;
    end else begin
      stg_q[0] <= async_i;
      for (int s = 1; s < int'(STAGES); s++) stg_q[s] <= stg_q[s-1];
      prev_q <= stg_q[STAGES-1];
    end
  end

  assign level_o = stg_q[STAGES-1];
  assign prev_o  = prev_q;
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int unsigned DATA_W    = 12,
  parameter int unsigned FRAME_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              shift_i,
  input  logic              clear_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              bit_o
);
  localparam int unsigned PAD_W = FRAME_LEN - DATA_W;

  logic [FRAME_LEN-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sr_q <= '0;
    else if (load_i)  sr_q <= {{PAD_W{1'b0}}, data_i};
    else if (clear_i) sr_q <= '0;
    else if (shift_i) sr_q <= {sr_q[FRAME_LEN-2:0], 1'b0};
  end

  assign bit_o = sr_q[FRAME_LEN-1];

  // R2
  first_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> !bit_o);
endmodule

// File: rtl/adc_rd_seq.sv
module adc_rd_seq #(
  parameter int unsigned FRAME_LEN = 16,
  parameter int unsigned TRACK_AT  = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_fall_i,
  input  logic cs_rise_i,
  input  logic cs_low_i,
  input  logic sclk_fall_i,
  output logic load_o,
  output logic shift_o,
  output logic clear_o,
  output logic oe_o,
  output logic hold_o,
  output logic done_o
);
  import adc_rd_pkg::*;

  localparam int unsigned CNT_W = $clog2(FRAME_LEN + 1);
  localparam logic [CNT_W-1:0] LAST_PRE  = CNT_W'(FRAME_LEN - 1);
  localparam logic [CNT_W-1:0] TRACK_PRE = CNT_W'(TRACK_AT - 1);

  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic             oe_q, hold_q, done_q;
  logic             run, step, finish, abort;

  assign run    = (ph_q == PH_RUN);
  assign step   = run && sclk_fall_i && cs_low_i && !cs_fall_i;
  assign finish = step && (cnt_q == LAST_PRE);
  assign abort  = run && cs_rise_i && !cs_fall_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      hold_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= finish;
      if (cs_fall_i) begin
        ph_q   <= PH_RUN;
        cnt_q  <= '0;
        oe_q   <= 1'b1;
        hold_q <= 1'b1;
      end else if (abort) begin
        ph_q   <= PH_IDLE;
        oe_q   <= 1'b0;
        hold_q <= 1'b0;
      end else if (step) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == TRACK_PRE) hold_q <= 1'b0;
        if (finish) begin
          ph_q <= PH_IDLE;
          oe_q <= 1'b0;
        end
      end
    end
  end

  assign load_o  = cs_fall_i;
  assign shift_o = step;
  assign clear_o = abort || finish;
  assign oe_o    = oe_q;
  assign hold_o  = hold_q;
  assign done_o  = done_q;

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall_i |=> (oe_q && hold_q && cnt_q == '0));
  // R4
  track_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_q) && run) |-> (cnt_q == CNT_W'(TRACK_AT)));
  // R5
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> (!oe_q && $past(oe_q) && cnt_q == CNT_W'(FRAME_LEN)));
  // R6
  abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && run) |=> (!oe_q && !hold_q && !done_q));
  // R7
  idle_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !cs_fall_i) |=> (!oe_q && $stable(cnt_q)));
  // R5
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_LEN));
endmodule

// File: rtl/adc_rd_top.sv
module adc_rd_top #(
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned TRACK_AT = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              sdata_o,
  output logic              sdata_oe_o,
  output logic              hold_o,
  output logic              done_o
);
  import adc_rd_pkg::*;

  localparam int unsigned FRAME_LEN = DATA_W + LEAD_ZEROS;

  logic [1:0] lvl, prv;
  logic       cs_fall, cs_rise, sclk_fall, cs_low;
  logic       load, shift, clear;

  // bit 0: chip-select (idles high), bit 1: serial clock
  adc_rd_sync #(.WIDTH(2), .STAGES(SYNC_DEPTH), .RST_VAL(2'b01)) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i ({sclk_i, cs_ni}),
    .level_o (lvl),
    .prev_o  (prv)
  );

  assign cs_fall   =  prv[0] & ~lvl[0];
  assign cs_rise   = ~prv[0] &  lvl[0];
  assign sclk_fall =  prv[1] & ~lvl[1];
  assign cs_low    = ~lvl[0];

  adc_rd_seq #(.FRAME_LEN(FRAME_LEN), .TRACK_AT(TRACK_AT)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_fall_i   (cs_fall),
    .cs_rise_i   (cs_rise),
    .cs_low_i    (cs_low),
    .sclk_fall_i (sclk_fall),
    .load_o      (load),
    .shift_o     (shift),
    .clear_o     (clear),
    .oe_o        (sdata_oe_o),
    .hold_o      (hold_o),
    .done_o      (done_o)
  );

  adc_rd_shift #(.DATA_W(DATA_W), .FRAME_LEN(FRAME_LEN)) u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .shift_i (shift),
    .clear_i (clear),
    .data_i  (result_i),
    .bit_o   (sdata_o)
  );

  // R10
  quiet_line_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sdata_oe_o |-> !sdata_o);
  // R4
  hold_with_oe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> sdata_oe_o);
endmodule

// File: tb/adc_rd_top_bench.sv
module adc_rd_top_bench;
  localparam int DW = 12;
  localparam int FL = DW + 4;
  localparam int SETTLE = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sclk = 1'b0;
  logic [DW-1:0] res = '0;
  logic sdata, oe, hold, done;
  int tests = 0, fails = 0, done_cnt = 0;

  always #2 clk = ~clk;

  adc_rd_top #(.DATA_W(DW)) u_adc_rd_top (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk),
    .result_i(res), .sdata_o(sdata), .sdata_oe_o(oe),
    .hold_o(hold), .done_o(done)
  );

  always @(posedge clk) if (rst_n && done) done_cnt <= done_cnt + 1;

  task automatic check(string req, int act, int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic settle();
    repeat (SETTLE) @(negedge clk);
  endtask

  task automatic pulse();
    sclk = 1'b1; repeat (4) @(negedge clk);
    sclk = 1'b0; settle();
  endtask

  function automatic int exp_bit(logic [DW-1:0] v, int k);
    return (k < 4) ? 0 : int'(v[FL-1-k]);
  endfunction

  // full frame; abort_at<FL raises chip-select after that many falls
  task automatic frame(logic [DW-1:0] v, int abort_at, bit scramble);
    int d0;
    res = v; d0 = done_cnt;
    cs_n = 1'b0; settle();
    if (scramble) res = ~v;  // R8
    check("R2 oe", int'(oe), 1);
    check("R2 hold", int'(hold), 1);
    check("R2 bit0", int'(sdata), 0);
    for (int k = 1; k <= FL; k++) begin
      if (k > abort_at) break;
      pulse();
      if (k < FL) begin
        check(scramble ? "R8 bit" : "R3 bit", int'(sdata), exp_bit(v, k));
        check("R4 hold", int'(hold), (k < 14) ? 1 : 0);
        check("R5 oe", int'(oe), 1);
        check("R5 no early done", done_cnt - d0, 0);
      end else begin
        check("R5 oe off", int'(oe), 0);
        check("R5 done once", done_cnt - d0, 1);
        check("R10 line", int'(sdata), 0);
      end
    end
    if (abort_at < FL) begin
      cs_n = 1'b1; settle();
      check("R6 oe", int'(oe), 0);
      check("R6 hold", int'(hold), 0);
      check("R6 no done", done_cnt - d0, 0);
      check("R10 line", int'(sdata), 0);
    end else begin
      for (int j = 0; j < 3; j++) pulse();
      check("R9 oe", int'(oe), 0);
      check("R9 done", done_cnt - d0, 1);
      cs_n = 1'b1; settle();
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 oe", int'(oe), 0);
    check("R1 hold", int'(hold), 0);
    check("R1 done", int'(done), 0);
    check("R1 data", int'(sdata), 0);
    rst_n = 1'b1; settle();
    check("R1 oe post", int'(oe), 0);

    for (int i = 0; i < 5; i++) pulse();
    check("R7 oe", int'(oe), 0);
    check("R7 done", done_cnt, 0);
    check("R10 line", int'(sdata), 0);

    frame(12'hFFF, FL, 1'b0);
    frame(12'h000, FL, 1'b0);
    for (int b = 0; b < DW; b++) frame(DW'(1) << b, FL, 1'b0);
    for (int v = 5; v < 4096; v += 409) frame(DW'(v), FL, 1'b0);
    frame(12'hA5C, FL, 1'b1);
    frame(12'h3C7, FL, 1'b1);
    for (int a = 0; a < FL; a++) frame(12'hB6D, a, 1'b0);

    for (int i = 0; i < 3; i++) pulse();
    frame(12'h8E1, FL, 1'b0);  // R7: restarts from bit 0

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule